// File: doc/BRIEF.md
# Root Port Error and PME Signalling Control

This block holds the root-control register of a PCI Express root port and turns error and power-management events into two requests for the rest of the chip. Configuration software reads and writes a single 16-bit register through a simple port with an address, byte enables and write data. Only the low four bits are writable. Three of them choose which error severities (correctable, non-fatal uncorrectable, fatal) may raise a system error. The fourth allows a power-management event interrupt.

Error events arrive as one-cycle strobes, one bit per severity. There are two strobe vectors: one for errors the port detects itself and one for error messages received from devices below it. Any strobe whose severity is enabled produces a single one-cycle system-error pulse. No other enable gates it. The PME interrupt request is a level that follows the enable bit ANDed with the root status PME flag. If the enable bit is set while the flag is already up, the request rises at once.

Top module: `rp_err_pme_ctl`

## Requirements
- R1: After reset the register reads 0x0000, and `serr_o` and `pme_irq_o` are low.
- R2: While `cfg_addr_i` equals 0x0BC, `cfg_rdata_o` shows the register. Any other address reads 0x0000.
- R3: Bits 15:4 always read as zero. Writes to them are discarded.
- R4: A write changes bits 7:0 only when `cfg_be_i[0]` is 1. With `cfg_be_i[0]` at 0 the register keeps its value.
- R5: A write with `cfg_wr_i` high to any address other than 0x0BC leaves the register unchanged.
- R6: The register's bits 0, 1 and 2 enable correctable, non-fatal and fatal errors. Bits 0, 1 and 2 of the event inputs carry those severities. An enabled event in cycle N makes `serr_o` high in cycle N+1.
- R7: Port-detected events (`port_err_i`) and received-message events (`msg_err_i`) are treated alike.
- R8: Any number of enabled events in the same cycle produce one single-cycle pulse. A cycle with no enabled event gives `serr_o` low in the next cycle.
- R9: An event whose severity bit is clear never raises `serr_o`. No other enable is consulted.
- R10: A register write acts at the clock edge. An event in the same cycle as the write is judged by the old value, and an event in the next cycle by the new value.
- R11: `pme_irq_o` in cycle N+1 equals register bit 3 AND `pme_status_i` in cycle N.
- R12: When bit 3 goes from 0 to 1 while `pme_status_i` is already high, `pme_irq_o` rises in the cycle after the new value takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 12 | Configuration byte address |
| cfg_be_i | input | 2 | Byte enables for the 16-bit write |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data, decoded combinationally from the address |
| port_err_i | input | 3 | Errors detected by the port, one strobe per severity |
| msg_err_i | input | 3 | Received error messages, one strobe per severity |
| pme_status_i | input | 1 | PME status flag from the root status register |
| serr_o | output | 1 | System-error pulse |
| pme_irq_o | output | 1 | PME interrupt request level |

## Verification
The hardest case to reach is the boundary between a write and an event in adjacent cycles. An event strobe has to land in exactly the cycle of an enable write to show that the old setting still decides. The PME flag has to be held high before its enable is turned on. Directed sequences set up both situations step by step. Random cycles then mix byte enables, stray addresses and simultaneous strobes from both sources, and a bench model applies the write only after it has judged that cycle's events.

// File: rtl/rp_ctl_pkg.sv
package rp_ctl_pkg;
  localparam int CFG_AW     = 12;
  localparam int REG_W      = 16;
  localparam int NUM_SEV    = 3;
  localparam int PME_EN_BIT = 3;
  localparam logic [CFG_AW-1:0] CTRL_OFFSET = 12'h0BC;
  localparam logic [REG_W-1:0]  CTRL_RW_MASK = 16'h000F;

  typedef enum int {SEV_CORR = 0, SEV_NONFATAL = 1, SEV_FATAL = 2} sev_e;
endpackage

// File: rtl/rp_ctl_reg.sv
module rp_ctl_reg
  import rp_ctl_pkg::*;
#(
  parameter int                 AW      = CFG_AW,
  parameter int                 DW      = REG_W,
  parameter logic [AW-1:0]      OFFSET  = CTRL_OFFSET,
  parameter logic [DW-1:0]      RW_MASK = CTRL_RW_MASK
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [DW-1:0]   ctrl_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] reg_q;
  logic          hit;

  assign hit = (addr_i == OFFSET);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q[b*8 +: 8] <= '0;
      else if (wr_i && hit && be_i[b])
        reg_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & RW_MASK[b*8 +: 8];
    end
  end

  assign rdata_o = hit ? reg_q : '0;
  assign ctrl_o  = reg_q;

  // R5
  stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit) |=> $stable(reg_q));

  // R4
  be_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && !be_i[0]) |=> $stable(reg_q[7:0]));
endmodule

// File: rtl/rp_serr_gen.sv
module rp_serr_gen
  import rp_ctl_pkg::*;
#(
  parameter int NSEV = NUM_SEV
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSEV-1:0] sev_en_i,
  input  logic [NSEV-1:0] port_err_i,
  input  logic [NSEV-1:0] msg_err_i,
  output logic            serr_o
);
  logic [NSEV-1:0] hit;
  logic            serr_q;

  for (genvar s = 0; s < NSEV; s++) begin : g_sev
    assign hit[s] = sev_en_i[s] & (port_err_i[s] | msg_err_i[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b0;
    else         serr_q <= |hit;
  end

  assign serr_o = serr_q;

  // R6
  serr_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sev_en_i & (port_err_i | msg_err_i))) |=> serr_o);

  // R9
  serr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sev_en_i & (port_err_i | msg_err_i))) |=> !serr_o);
endmodule

// File: rtl/rp_pme_irq.sv
module rp_pme_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pme_en_i,
  input  logic pme_status_i,
  output logic irq_o
);
  logic irq_q;
  logic en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      irq_q <= pme_en_i & pme_status_i;
      en_d  <= pme_en_i;
    end
  end

  assign irq_o = irq_q;

  // R12
  arm_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pme_en_i && !en_d && pme_status_i) |=> irq_o);

  // R11
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pme_en_i && pme_status_i));
endmodule

// File: rtl/rp_err_pme_ctl.sv
module rp_err_pme_ctl
  import rp_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [REG_W/8-1:0] cfg_be_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic [NUM_SEV-1:0] port_err_i,
  input  logic [NUM_SEV-1:0] msg_err_i,
  input  logic              pme_status_i,
  output logic              serr_o,
  output logic              pme_irq_o
);
  logic [REG_W-1:0] ctrl;

  rp_ctl_reg #(
    .AW(CFG_AW), .DW(REG_W), .OFFSET(CTRL_OFFSET), .RW_MASK(CTRL_RW_MASK)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .addr_i  (cfg_addr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ctrl_o  (ctrl)
  );

  rp_serr_gen #(.NSEV(NUM_SEV)) u_serr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sev_en_i   (ctrl[NUM_SEV-1:0]),
    .port_err_i (port_err_i),
    .msg_err_i  (msg_err_i),
    .serr_o     (serr_o)
  );

  rp_pme_irq u_pme (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pme_en_i     (ctrl[PME_EN_BIT]),
    .pme_status_i (pme_status_i),
    .irq_o        (pme_irq_o)
  );
endmodule

// File: tb/rp_err_pme_ctl_tb.sv
module rp_err_pme_ctl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [11:0] cfg_addr_i = '0;
  logic [1:0]  cfg_be_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic [2:0]  port_err_i = '0;
  logic [2:0]  msg_err_i = '0;
  logic        pme_status_i = 1'b0;
  logic        serr_o;
  logic        pme_irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] m_ctrl = '0;

  localparam logic [11:0] OFF = 12'h0BC;

  always #5 clk_i = ~clk_i;

  rp_err_pme_ctl dut_i (.*);

  function automatic logic f_serr(logic [3:0] c, logic [2:0] a, logic [2:0] b);
    return |(c[2:0] & (a | b));
  endfunction

  function automatic logic f_irq(logic [3:0] c, logic st);
    return c[3] & st;
  endfunction

  function automatic logic [15:0] f_rd(logic [3:0] c, logic [11:0] a);
    return (a == OFF) ? {12'h000, c} : 16'h0000;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // driven at negedge; checks at the following negedge
  task automatic step(logic wr, logic [11:0] a, logic [1:0] be, logic [15:0] d,
                      logic [2:0] pe, logic [2:0] me, logic st);
    logic es, ei;
    cfg_wr_i = wr; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    port_err_i = pe; msg_err_i = me; pme_status_i = st;
    es = f_serr(m_ctrl, pe, me);
    ei = f_irq(m_ctrl, st);
    if (wr && a == OFF && be[0]) m_ctrl = d[3:0];
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6", {15'h0, serr_o}, {15'h0, es});
    chk("R11", {15'h0, pme_irq_o}, {15'h0, ei});
    chk("R2", cfg_rdata_o, f_rd(m_ctrl, a));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    cfg_addr_i = OFF;
    #1;
    // R1
    chk("R1", cfg_rdata_o, 16'h0000);
    chk("R1", {14'h0, serr_o, pme_irq_o}, 16'h0);
    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", cfg_rdata_o, 16'h0000);

    // R3: reserved bits discarded
    step(1, OFF, 2'b11, 16'hFFFF, 0, 0, 0);
    chk("R3", cfg_rdata_o, 16'h000F);
    // R4: low byte disabled keeps value
    step(1, OFF, 2'b10, 16'h0000, 0, 0, 0);
    chk("R4", cfg_rdata_o, 16'h000F);
    // R5: write elsewhere; read back at offset
    step(1, 12'h0B8, 2'b11, 16'h0000, 0, 0, 0);
    step(0, OFF, 2'b00, 16'h0, 0, 0, 0);
    chk("R5", cfg_rdata_o, 16'h000F);
    // R2: other address reads zero
    step(0, 12'h0BE, 2'b00, 16'h0, 0, 0, 0);
    chk("R2", cfg_rdata_o, 16'h0000);
    // R8: all severities from both sources -> single pulse
    step(0, OFF, 0, 0, 3'b111, 3'b111, 0);
    chk("R8", {15'h0, serr_o}, 16'h1);
    step(0, OFF, 0, 0, 0, 0, 0);
    chk("R8", {15'h0, serr_o}, 16'h0);
    // R7: message source only, fatal
    step(0, OFF, 0, 0, 3'b000, 3'b100, 0);
    chk("R7", {15'h0, serr_o}, 16'h1);
    // R9: only correctable enabled, non-fatal/fatal ignored
    step(1, OFF, 2'b01, 16'h0001, 0, 0, 0);
    step(0, OFF, 0, 0, 3'b110, 3'b010, 0);
    chk("R9", {15'h0, serr_o}, 16'h0);
    // R10: write enabling fatal with fatal event in same cycle -> old value
    step(1, OFF, 2'b01, 16'h0004, 3'b100, 0, 0);
    chk("R10", {15'h0, serr_o}, 16'h0);
    step(0, OFF, 0, 0, 3'b100, 0, 0);
    chk("R10", {15'h0, serr_o}, 16'h1);
    // R12: pending status, then enable
    step(0, OFF, 0, 0, 0, 0, 1);
    step(0, OFF, 0, 0, 0, 0, 1);
    chk("R12", {15'h0, pme_irq_o}, 16'h0);
    step(1, OFF, 2'b01, 16'h0008, 0, 0, 1);
    step(0, OFF, 0, 0, 0, 0, 1);
    chk("R12", {15'h0, pme_irq_o}, 16'h1);
    step(0, OFF, 0, 0, 0, 0, 0);
    chk("R11", {15'h0, pme_irq_o}, 16'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic        wr;
      logic [11:0] a;
      int unsigned r;
      r  = $urandom;
      wr = (r[2:0] < 3);
      a  = (r[5:3] == 0) ? 12'($urandom) : ((r[5:3] == 1) ? (OFF ^ 12'(1 << r[9:6])) : OFF);
      step(wr, a, 2'($urandom), 16'($urandom),
           (r[12:10] == 0) ? 3'($urandom) : 3'b000,
           (r[15:13] == 0) ? 3'($urandom) : 3'b000,
           r[16] | r[17]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule